// File: doc/BRIEF.md
# Serial Register Access Port

This block is a synchronous serial slave. Through it a host controller reads and writes a bank of sixteen 8-bit registers that belong to the surrounding core. The host lowers chip select and shifts in a command byte. One data byte follows, or a run of data bytes, clocked by the host's serial clock. That clock is independent of the core clock. The port oversamples chip select, serial clock and serial data with the core clock, so every register-file access is a plain synchronous event in the core domain. The serial clock's high and low phases must each last at least six core clock cycles.

The command byte travels least-significant bit first and carries five fields:

- the access direction;
- a 4-bit register address;
- a device-select bit, which makes the port stand aside so another device can share the same chip select;
- a reserved bit;
- a burst bit.

With the burst bit set, the register address advances after every data byte and wraps from 15 back to 0. This continues until chip select rises. On the core side the port presents an address, write data and a one-clock write strobe. It takes read data back combinationally for the presented address.

Top module: `serreg_port`

## Requirements
- R1: The first 8 bits after chip select falls form the command byte. Command bit 0 gives the direction (1 read, 0 write), bits 1..4 give the register address with bit 1 as its LSB, bit 5 is device select, bit 6 is reserved and bit 7 selects burst (1) or single (0) access.
- R2: Every byte moves LSB first in both directions, and serial input is sampled on the rising serial-clock edge.
- R3: Read data on `sdo` changes only after a falling serial-clock edge and stays constant through the following high phase.
- R4: A write produces exactly one `rf_we` pulse, one core clock wide, after the 8th data bit has been sampled, with `rf_addr` and `rf_wdata` carrying the addressed register and the received byte.
- R5: A single read returns, LSB first, the value the register file holds at the commanded address. `sdo_en` rises at the first falling edge of the data phase, and `sdo_en` is never high while `rf_we` is high.
- R6: With device select = 1 the transaction has no effect: no write strobe, and `sdo_en` stays low throughout.
- R7: With the reserved bit = 1 the transaction is ignored in the same way as in R6.
- R8: A burst write stores successive data bytes at successive addresses starting at the commanded one, wrapping from 15 to 0.
- R9: A burst read returns successive registers starting at the commanded address, wrapping from 15 to 0.
- R10: Chip select rising at any bit position aborts the transaction. A partly received byte is not written, and the next transaction starts with a fresh command byte.
- R11: In single mode, data bytes after the first have no effect: no further write, and `sdo_en` drops at the first falling edge after the data byte.
- R12: After reset, and from one core clock after chip select is seen high, `sdo_en` and `rf_we` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select from the host, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the host |
| sdo_en | output | 1 | High while the port drives `sdo` (pad output enable) |
| rf_addr | output | 4 | Register address toward the core |
| rf_wdata | output | 8 | Write data toward the core |
| rf_we | output | 1 | One-clock write strobe toward the core |
| rf_rdata | input | 8 | Read data of the register at `rf_addr` |

## Verification
On every cycle, the assertions check that the write strobe is one clock wide and always follows a completed byte, and that `sdo` moves only right after a detected falling edge. They also check that the output enable is dropped once chip select is high, and that it is never asserted during an ignored transaction or together with a write. The scenarios are needed for everything that depends on data values and ordering: the bit order of command and data, the field positions, address increment and wrap in both burst directions, ignored transactions leaving the registers unchanged, and aborts leaving partial bytes unwritten.

// File: rtl/serreg_pkg.sv
package serreg_pkg;

  localparam int REG_DW = 8;
  localparam int REG_AW = 4;
  localparam int REG_N  = 1 << REG_AW;
  localparam int CNT_W  = $clog2(REG_DW);

  // command layout, lowest bit first on the wire
  typedef struct packed {
    logic              burst;
    logic              rsv;
    logic              dsel;
    logic [REG_AW-1:0] addr;
    logic              rd;
  } cmd_t;

  typedef enum logic [2:0] {
    PS_CMD  = 3'd0,
    PS_WR   = 3'd1,
    PS_RD   = 3'd2,
    PS_IGN  = 3'd3,
    PS_DONE = 3'd4
  } pst_t;

  function automatic cmd_t cmd_decode(input logic [REG_DW-1:0] b);
    return cmd_t'(b);
  endfunction

  function automatic logic cmd_foreign(input cmd_t c);
    return c.dsel | c.rsv;
  endfunction

  function automatic logic [REG_AW-1:0] addr_next(input logic [REG_AW-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic [REG_DW-1:0] lsb_shift_in(input logic [REG_DW-1:0] cur,
                                                     input logic b);
    return {b, cur[REG_DW-1:1]};
  endfunction

endpackage

// File: rtl/regport_sync.sv
module regport_sync #(
  parameter int          N       = 3,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  generate
    for (genvar g = 0; g < N; g++) begin : g_bit
      if (STAGES <= 1) begin : g_one
        logic ff;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) ff <= RST_VAL[g];
          else        ff <= d[g];
        end
        assign q[g] = ff;
      end else begin : g_chain
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
          else        chain <= {chain[STAGES-2:0], d[g]};
        end
        assign q[g] = chain[STAGES-1];
      end
    end
  endgenerate

endmodule

// File: rtl/regport_edge.sv
module regport_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);

  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

endmodule

// File: rtl/regport_shift.sv
module regport_shift
  import serreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              rise,
  input  logic              din,
  output logic              byte_done,
  output logic [REG_DW-1:0] byte_q
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(REG_DW - 1);

  logic [CNT_W-1:0]  cnt;
  logic [REG_DW-1:0] sr;
  logic [REG_DW-1:0] sr_nxt;

  assign sr_nxt = lsb_shift_in(sr, din);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      sr        <= '0;
      byte_done <= 1'b0;
      byte_q    <= '0;
    end else begin
      byte_done <= 1'b0;
      if (!active) begin
        cnt <= '0;
      end else if (rise) begin
        sr  <= sr_nxt;
        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        if (cnt == LAST) begin
          byte_done <= 1'b1;
          byte_q    <= sr_nxt;
        end
      end
    end
  end

endmodule

// File: rtl/regport_ctrl.sv
module regport_ctrl
  import serreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              fall,
  input  logic              byte_done,
  input  logic [REG_DW-1:0] byte_q,
  input  logic [REG_DW-1:0] rf_rdata,
  output logic [REG_AW-1:0] rf_addr,
  output logic [REG_DW-1:0] rf_wdata,
  output logic              rf_we,
  output logic              sdo,
  output logic              sdo_en,
  output logic              ignoring
);

  pst_t              state;
  logic              burst;
  logic              load_pend;
  logic [REG_DW-1:0] tx;
  cmd_t              cmd_in;

  assign cmd_in   = cmd_decode(byte_q);
  assign ignoring = (state == PS_IGN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= PS_CMD;
      burst     <= 1'b0;
      load_pend <= 1'b0;
      tx        <= '0;
      rf_addr   <= '0;
      rf_wdata  <= '0;
      rf_we     <= 1'b0;
      sdo       <= 1'b0;
      sdo_en    <= 1'b0;
    end else begin
      rf_we <= 1'b0;
      if (!active) begin
        state     <= PS_CMD;
        sdo_en    <= 1'b0;
        load_pend <= 1'b0;
      end else begin
        // fetch read data one clock after the address has settled
        if (load_pend) begin
          tx        <= rf_rdata;
          load_pend <= 1'b0;
        end
        // burst write: step the address once the strobe has gone out
        if (rf_we && burst) rf_addr <= addr_next(rf_addr);

        unique case (state)
          PS_CMD: begin
            if (byte_done) begin
              if (cmd_foreign(cmd_in)) begin
                state <= PS_IGN;
              end else begin
                rf_addr <= cmd_in.addr;
                burst   <= cmd_in.burst;
                if (cmd_in.rd) begin
                  state     <= PS_RD;
                  load_pend <= 1'b1;
                end else begin
                  state <= PS_WR;
                end
              end
            end
          end
          PS_RD: begin
            if (fall) begin
              sdo    <= tx[0];
              tx     <= tx >> 1;
              sdo_en <= 1'b1;
            end
            if (byte_done) begin
              if (burst) begin
                rf_addr   <= addr_next(rf_addr);
                load_pend <= 1'b1;
              end else begin
                state <= PS_DONE;
              end
            end
          end
          PS_WR: begin
            if (byte_done) begin
              rf_we    <= 1'b1;
              rf_wdata <= byte_q;
              if (!burst) state <= PS_DONE;
            end
          end
          PS_DONE: begin
            if (fall) sdo_en <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/serreg_port.sv
module serreg_port
  import serreg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_en,
  output logic [REG_AW-1:0] rf_addr,
  output logic [REG_DW-1:0] rf_wdata,
  output logic              rf_we,
  input  logic [REG_DW-1:0] rf_rdata
);

  logic              cs_s, sclk_s, sdi_s;
  logic              cs_act;
  logic              sclk_rise, sclk_fall;
  logic              byte_done;
  logic [REG_DW-1:0] byte_q;
  logic              ignoring;

  regport_sync #(
    .N       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b001)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sdi, sclk, cs_n}),
    .q     ({sdi_s, sclk_s, cs_s})
  );

  assign cs_act = ~cs_s;

  regport_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (sclk_s),
    .rise  (sclk_rise),
    .fall  (sclk_fall)
  );

  regport_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (cs_act),
    .rise      (sclk_rise),
    .din       (sdi_s),
    .byte_done (byte_done),
    .byte_q    (byte_q)
  );

  regport_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (cs_act),
    .fall      (sclk_fall),
    .byte_done (byte_done),
    .byte_q    (byte_q),
    .rf_rdata  (rf_rdata),
    .rf_addr   (rf_addr),
    .rf_wdata  (rf_wdata),
    .rf_we     (rf_we),
    .sdo       (sdo),
    .sdo_en    (sdo_en),
    .ignoring  (ignoring)
  );

endmodule

// File: rtl/serreg_port_chk.sv
module serreg_port_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_act,
  input logic sclk_fall,
  input logic byte_done,
  input logic ignoring,
  input logic sdo,
  input logic sdo_en,
  input logic rf_we
);

  assert_we_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);

  assert_we_after_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> $past(byte_done));

  assert_sdo_fall_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $past(sclk_fall));

  assert_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !sdo_en);

  // covers both the device-select case and the reserved-bit case (R7)
  assert_ignore_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ignoring |-> (!rf_we && !sdo_en));

  assert_no_drive_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> !sdo_en);

endmodule

bind serreg_port serreg_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_act    (cs_act),
  .sclk_fall (sclk_fall),
  .byte_done (byte_done),
  .ignoring  (ignoring),
  .sdo       (sdo),
  .sdo_en    (sdo_en),
  .rf_we     (rf_we)
);

// File: tb/serreg_port_tb.sv
module serreg_port_tb;

  localparam int HALF = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       cs_n  = 1'b1;
  logic       sclk  = 1'b0;
  logic       sdi   = 1'b0;
  logic       sdo, sdo_en, rf_we;
  logic [3:0] rf_addr;
  logic [7:0] rf_wdata;
  logic [7:0] rf_rdata;

  logic [7:0] regs  [16];
  logic [3:0] log_a [16];
  logic [7:0] log_d [16];
  int         we_count = 0;
  int         en_cnt   = 0;
  int         held_bad = 0;
  int         tests    = 0;
  int         fails    = 0;

  serreg_port u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .sdi      (sdi),
    .sdo      (sdo),
    .sdo_en   (sdo_en),
    .rf_addr  (rf_addr),
    .rf_wdata (rf_wdata),
    .rf_we    (rf_we),
    .rf_rdata (rf_rdata)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'(8'h3C + i * 17);
  endfunction

  // core-side register file model
  assign rf_rdata = regs[rf_addr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) regs[i] <= init_val(i);
      we_count <= 0;
    end else if (rf_we) begin
      regs[rf_addr]        <= rf_wdata;
      log_a[we_count[3:0]] <= rf_addr;
      log_d[we_count[3:0]] <= rf_wdata;
      we_count             <= we_count + 1;
    end
  end

  always @(negedge clk) if (sdo_en) en_cnt <= en_cnt + 1;

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mkcmd(input logic rd, input logic [3:0] a,
                                       input logic ds, input logic rsv,
                                       input logic burst);
    return {burst, rsv, ds, a, rd};
  endfunction

  task automatic sbit(input logic b, output logic r);
    sdi = b;
    repeat (HALF) @(negedge clk);
    r = sdo;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    if (sdo_en && (sdo !== r)) held_bad++;
    sclk = 1'b0;
  endtask

  task automatic sbyte(input logic [7:0] t, output logic [7:0] r);
    logic [7:0] acc;
    logic       bit_r;
    for (int i = 0; i < 8; i++) begin
      sbit(t[i], bit_r);
      acc[i] = bit_r;
    end
    r = acc;
  endtask

  task automatic begin_x();
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic end_x();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic wr_single(input logic [3:0] a, input logic [7:0] d);
    logic [7:0] junk;
    begin_x();
    sbyte(mkcmd(1'b0, a, 1'b0, 1'b0, 1'b0), junk);
    sbyte(d, junk);
    end_x();
  endtask

  task automatic rd_single(input logic [3:0] a, output logic [7:0] v);
    logic [7:0] junk;
    begin_x();
    sbyte(mkcmd(1'b1, a, 1'b0, 1'b0, 1'b0), junk);
    sbyte(8'h00, v);
    end_x();
  endtask

  task automatic t_reset();
    check("R12 sdo_en after reset", int'(sdo_en), 0);
    check("R12 rf_we after reset", int'(rf_we), 0);
  endtask

  task automatic t_single_write_read();
    logic [7:0] v;
    int         wc0, en0;
    wc0 = we_count;
    wr_single(4'd3, 8'h5A);
    check("R4 one strobe per write", we_count - wc0, 1);
    check("R1 write address field", int'(log_a[wc0[3:0]]), 3);
    check("R2 write data lsb first", int'(log_d[wc0[3:0]]), 8'h5A);
    wr_single(4'd12, 8'h1E);
    check("R1 address bit 4 position", int'(log_a[wc0[3:0] + 4'd1]), 12);
    en0 = en_cnt;
    rd_single(4'd3, v);
    check("R5 read returns written value", int'(v), 8'h5A);
    check("R5 output enabled during read", int'(en_cnt > en0), 1);
    rd_single(4'd12, v);
    check("R2 read bit order", int'(v), 8'h1E);
    check("R3 read bits held through high phase", held_bad, 0);
    check("R12 output released after cs high", int'(sdo_en), 0);
  endtask

  task automatic t_read_pattern();
    logic [7:0] v;
    rd_single(4'd9, v);
    check("R5 read untouched register", int'(v), int'(init_val(9)));
  endtask

  task automatic t_device_select();
    logic [7:0] junk, v;
    int         wc0, en0;
    wc0 = we_count;
    en0 = en_cnt;
    begin_x();
    sbyte(mkcmd(1'b0, 4'd3, 1'b1, 1'b0, 1'b0), junk);
    sbyte(8'hFF, junk);
    end_x();
    begin_x();
    sbyte(mkcmd(1'b1, 4'd3, 1'b1, 1'b0, 1'b1), junk);
    sbyte(8'h00, junk);
    sbyte(8'h00, junk);
    end_x();
    check("R6 no write when device select set", we_count - wc0, 0);
    check("R6 no drive when device select set", en_cnt - en0, 0);
    rd_single(4'd3, v);
    check("R6 register unchanged", int'(v), 8'h5A);
  endtask

  task automatic t_reserved();
    logic [7:0] junk, v;
    int         wc0, en0;
    wc0 = we_count;
    en0 = en_cnt;
    begin_x();
    sbyte(mkcmd(1'b0, 4'd4, 1'b0, 1'b1, 1'b0), junk);
    sbyte(8'hC3, junk);
    end_x();
    check("R7 no write when reserved bit set", we_count - wc0, 0);
    check("R7 no drive when reserved bit set", en_cnt - en0, 0);
    rd_single(4'd4, v);
    check("R7 register unchanged", int'(v), int'(init_val(4)));
  endtask

  task automatic t_burst_write();
    logic [7:0] junk;
    logic [7:0] d [4];
    int         wc0;
    d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33; d[3] = 8'h44;
    wc0 = we_count;
    begin_x();
    sbyte(mkcmd(1'b0, 4'd14, 1'b0, 1'b0, 1'b1), junk);
    for (int i = 0; i < 4; i++) sbyte(d[i], junk);
    end_x();
    check("R8 burst write count", we_count - wc0, 4);
    for (int i = 0; i < 4; i++) begin
      check("R8 burst write address", int'(log_a[4'(wc0 + i)]), (14 + i) % 16);
      check("R8 burst write data", int'(log_d[4'(wc0 + i)]), int'(d[i]));
    end
  endtask

  task automatic t_burst_read();
    logic [7:0] junk, v;
    begin_x();
    sbyte(mkcmd(1'b1, 4'd15, 1'b0, 1'b0, 1'b1), junk);
    for (int i = 0; i < 3; i++) begin
      sbyte(8'h00, v);
      check("R9 burst read data", int'(v), int'(regs[(15 + i) % 16]));
    end
    end_x();
    check("R3 burst read bits held", held_bad, 0);
  endtask

  task automatic t_single_extra();
    logic [7:0] junk, v;
    int         wc0;
    wc0 = we_count;
    begin_x();
    sbyte(mkcmd(1'b0, 4'd7, 1'b0, 1'b0, 1'b0), junk);
    sbyte(8'h6B, junk);
    sbyte(8'h99, junk);
    end_x();
    check("R11 single write stores once", we_count - wc0, 1);
    check("R11 first byte kept", int'(regs[7]), 8'h6B);
    begin_x();
    sbyte(mkcmd(1'b1, 4'd7, 1'b0, 1'b0, 1'b0), junk);
    sbyte(8'h00, v);
    sbyte(8'h00, junk);
    check("R11 output released after single byte", int'(sdo_en), 0);
    end_x();
    check("R5 single read value", int'(v), 8'h6B);
  endtask

  task automatic t_abort();
    logic [7:0] junk, v;
    logic       r;
    int         wc0;
    wc0 = we_count;
    begin_x();
    sbyte(mkcmd(1'b0, 4'd5, 1'b0, 1'b0, 1'b0), junk);
    for (int i = 0; i < 4; i++) sbit(1'b1, r);
    end_x();
    check("R10 partial byte not written", we_count - wc0, 0);
    rd_single(4'd5, v);
    check("R10 register intact after abort", int'(v), int'(init_val(5)));
    begin_x();
    sbit(1'b1, r);
    sbit(1'b0, r);
    sbit(1'b0, r);
    end_x();
    wr_single(4'd6, 8'hA7);
    check("R10 fresh command after abort", int'(log_a[wc0[3:0]]), 6);
    check("R10 data after abort", int'(regs[6]), 8'hA7);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_single_write_read();
    t_read_pattern();
    t_device_select();
    t_reserved();
    t_burst_write();
    t_burst_read();
    t_single_extra();
    t_abort();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule